// File: doc/BRIEF.md
# I2C Port Expander Register Bank

This block is the register core of a sixteen-pin, two-port I/O expander placed behind an I2C target front end. That front end delivers byte-level events to it: the start of a write, the start of a read, a received byte with a flag that marks the first byte after the address, and a strobe that asks for the next byte to send. The block keeps a three-bit register pointer and eight byte-wide registers. Each of four groups (pin input, pin output, input polarity, pin direction) has one register for port 0 and one for port 1.

The first byte of a write transaction is the command byte. It loads the pointer. Later bytes, whether written or read, move back and forth between the two registers of the selected pair. The pointer keeps its value after a transaction ends. A later read can therefore return to the pair that was selected before without sending a new command.

The block drives the value of each pin and the enable of each pin driver. It also samples the pin levels through a synchronizer.

Top module: `gpx_regbank`

## Requirements
- R1: While reset is asserted and after it is released, both output registers hold 0xFF, both polarity registers hold 0x00, both direction registers hold 0xFF, the pointer holds 0 and `rd_data` holds 0x00. As a result `pin_out` is 0xFFFF and `pin_oe` is 0x0000.
- R2: In a write transaction, the byte flagged as first loads bits [2:0] of the byte into the pointer, and bits [7:3] are ignored. Pointer values are: 0/1 for input port 0/1, 2/3 for output port 0/1, 4/5 for polarity port 0/1, and 6/7 for direction port 0/1. Bit 0 of the pointer selects the port.
- R3: A byte received during a read transaction never changes the pointer, even when it is flagged as first.
- R4: Each data byte that is written, and each byte request, inverts pointer bit 0 and leaves bits 2:1 unchanged.
- R5: The pointer keeps its value across transactions. A read transaction starts at the register the pointer held when the previous transaction ended.
- R6: A write to an output register appears on its pin_out byte (port 0 on bits 7:0, port 1 on bits 15:8) one clock later. A direction bit of 0 sets the matching `pin_oe` bit to 1, and a direction bit of 1 clears it.
- R7: A read of an input register returns the synchronized level of the port's pins, XORed bitwise with that port's polarity register.
- R8: `rd_data` is loaded only at the clock edge where a byte request is sampled, and it holds until the next request. An input read returns the pin level that was present `SYNC_STAGES` edges before the request edge. A change of the pins in the request cycle is not seen by that read.
- R9: A data byte written while the pointer selects an input register changes no register and no pin. The pointer still toggles bit 0.
- R10: A read of an output, polarity or direction register returns the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released internally in step with the clock |
| wr_start | input | 1 | One-cycle pulse: a write transaction begins |
| rd_start | input | 1 | One-cycle pulse: a read transaction begins |
| byte_valid | input | 1 | A received byte is present on byte_data |
| byte_first | input | 1 | The received byte is the first byte after the address |
| byte_data | input | 8 | Received byte |
| byte_req | input | 1 | The front end asks for the next byte to send |
| rd_data | output | 8 | Byte to send, loaded on a request |
| pin_in | input | 16 | Pin levels (port 1 on bits 15:8) |
| pin_out | output | 16 | Pin drive values |
| pin_oe | output | 16 | Pin driver enables, active high |

## Verification
Two functions can fall in the same clock cycle: the capture of an input byte for a read, and a change of the pins themselves. The bench drives a new pin pattern in the same cycle as the byte request. It then checks that the captured byte still shows the older, synchronized level. It also checks that this byte stays unchanged over several idle cycles while the new level has passed through the synchronizer. A later request on the same register must return the new level.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int PTR_W = 3;

  typedef enum logic [1:0] {
    GRP_IN  = 2'd0,
    GRP_OUT = 2'd1,
    GRP_POL = 2'd2,
    GRP_DIR = 2'd3
  } grp_e;

  typedef struct packed {
    grp_e grp;
    logic port;
  } ptr_t;
endpackage

// File: rtl/gpx_rst_sync.sv
module gpx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpx_pin_sync.sv
module gpx_pin_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_synced
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pin_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign pin_synced = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_cmd_ctrl.sv
module gpx_cmd_ctrl
  import gpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_start,
  input  logic             rd_start,
  input  logic             byte_valid,
  input  logic             byte_first,
  input  logic [PTR_W-1:0] cmd_bits,
  input  logic             byte_req,
  output ptr_t             ptr,
  output logic             in_wr,
  output logic             wr_en,
  output logic             rd_en
);
  ptr_t ptr_q, ptr_d;
  logic in_wr_q, in_wr_d;
  logic cmd_hit, dat_hit, req_hit;

  always_comb begin
    cmd_hit = byte_valid &  byte_first & in_wr_q;
    dat_hit = byte_valid & ~byte_first & in_wr_q;
    req_hit = byte_req & ~byte_valid;

    in_wr_d = in_wr_q;
    if (wr_start)      in_wr_d = 1'b1;
    else if (rd_start) in_wr_d = 1'b0;

    ptr_d = ptr_q;
    if (cmd_hit)                ptr_d = ptr_t'(cmd_bits);
    else if (dat_hit | req_hit) ptr_d.port = ~ptr_q.port;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      in_wr_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      in_wr_q <= in_wr_d;
    end
  end

  assign ptr   = ptr_q;
  assign in_wr = in_wr_q;
  assign wr_en = dat_hit;
  assign rd_en = req_hit;
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NPORT  = 2,
  localparam int PINS  = PORT_W * NPORT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  ptr_t              sel,
  input  logic [PORT_W-1:0] wr_byte,
  input  logic [PINS-1:0]   pin_level,
  output logic [PORT_W-1:0] rd_data,
  output logic [PINS-1:0]   drive_bits,
  output logic [PINS-1:0]   dir_bits
);
  localparam logic [PORT_W-1:0] OUT_RST = '1;
  localparam logic [PORT_W-1:0] POL_RST = '0;
  localparam logic [PORT_W-1:0] DIR_RST = '1;

  logic [NPORT-1:0][PORT_W-1:0] out_q, out_d;
  logic [NPORT-1:0][PORT_W-1:0] pol_q, pol_d;
  logic [NPORT-1:0][PORT_W-1:0] dir_q, dir_d;
  logic [NPORT-1:0][PORT_W-1:0] in_view;
  logic [PORT_W-1:0]            rd_q, rd_d, rd_mux;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign in_view[p] = pin_level[p*PORT_W +: PORT_W] ^ pol_q[p];
    assign drive_bits[p*PORT_W +: PORT_W] = out_q[p];
    assign dir_bits[p*PORT_W +: PORT_W]   = dir_q[p];
  end

  always_comb begin
    out_d = out_q;
    pol_d = pol_q;
    dir_d = dir_q;
    if (wr_en) begin
      unique case (sel.grp)
        GRP_OUT: out_d[sel.port] = wr_byte;
        GRP_POL: pol_d[sel.port] = wr_byte;
        GRP_DIR: dir_d[sel.port] = wr_byte;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel.grp)
      GRP_IN:  rd_mux = in_view[sel.port];
      GRP_OUT: rd_mux = out_q[sel.port];
      GRP_POL: rd_mux = pol_q[sel.port];
      default: rd_mux = dir_q[sel.port];
    endcase
    rd_d = rd_en ? rd_mux : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORT; p++) begin
        out_q[p] <= OUT_RST;
        pol_q[p] <= POL_RST;
        dir_q[p] <= DIR_RST;
      end
      rd_q <= '0;
    end else begin
      out_q <= out_d;
      pol_q <= pol_d;
      dir_q <= dir_d;
      rd_q  <= rd_d;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank
  import gpx_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  localparam int NPORT      = 2,
  localparam int PINS       = PORT_W * NPORT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic              rd_start,
  input  logic              byte_valid,
  input  logic              byte_first,
  input  logic [PORT_W-1:0] byte_data,
  input  logic              byte_req,
  output logic [PORT_W-1:0] rd_data,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  logic            rst_sync_n;
  ptr_t            ptr_q;
  logic            in_wr, wr_en, rd_en;
  logic [PINS-1:0] pin_level, drive_bits, dir_bits;

  gpx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpx_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_pins (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pin_async  (pin_in),
    .pin_synced (pin_level)
  );

  gpx_cmd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_start   (wr_start),
    .rd_start   (rd_start),
    .byte_valid (byte_valid),
    .byte_first (byte_first),
    .cmd_bits   (byte_data[PTR_W-1:0]),
    .byte_req   (byte_req),
    .ptr        (ptr_q),
    .in_wr      (in_wr),
    .wr_en      (wr_en),
    .rd_en      (rd_en)
  );

  gpx_regfile #(.PORT_W(PORT_W), .NPORT(NPORT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .sel        (ptr_q),
    .wr_byte    (byte_data),
    .pin_level  (pin_level),
    .rd_data    (rd_data),
    .drive_bits (drive_bits),
    .dir_bits   (dir_bits)
  );

  assign pin_out = drive_bits;
  assign pin_oe  = ~dir_bits;
endmodule

// File: rtl/gpx_regbank_chk.sv
module gpx_regbank_chk #(
  parameter int PORT_W = 8,
  parameter int PINS   = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              byte_valid,
  input logic              byte_first,
  input logic [PORT_W-1:0] byte_data,
  input logic              byte_req,
  input logic              in_wr,
  input logic [2:0]        ptr,
  input logic [PORT_W-1:0] rd_data,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe
);
  assert_cmd_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    byte_valid && byte_first && in_wr |=> ptr == $past(byte_data[2:0]));

  assert_read_no_cmd_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    byte_valid && !in_wr |=> $stable(ptr));

  assert_req_toggle_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    byte_req && !byte_valid |=> ptr == {$past(ptr[2:1]), ~$past(ptr[0])});

  assert_out_moves_on_write_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(pin_out) |-> $past(byte_valid));

  assert_oe_moves_on_write_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(pin_oe) |-> $past(byte_valid));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(rd_data) |-> $past(byte_req));

  assert_input_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    byte_valid && !byte_first && in_wr && ptr[2:1] == 2'b00 |=> $stable(pin_out) && $stable(pin_oe));
endmodule

bind gpx_regbank gpx_regbank_chk #(.PORT_W(PORT_W), .PINS(PINS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .byte_valid (byte_valid),
  .byte_first (byte_first),
  .byte_data  (byte_data),
  .byte_req   (byte_req),
  .in_wr      (in_wr),
  .ptr        (ptr_q),
  .rd_data    (rd_data),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe)
);

// File: tb/tb_gpx_regbank.sv
module tb_gpx_regbank;
  localparam logic [2:0] OP_PIN = 3'd0, OP_WCMD = 3'd1, OP_WDAT = 3'd2, OP_RSTART = 3'd3,
                         OP_RD = 3'd4, OP_CKOUT = 3'd5, OP_RCMD = 3'd6;
  localparam int NV = 36;
  localparam int WD_CYCLES = 20000;

  // {req[3:0], op[2:0], data[15:0], expect[15:0]}
  localparam logic [38:0] VEC [NV] = '{
    {4'd7,  OP_PIN,    16'hA53C, 16'h0000},
    {4'd2,  OP_WCMD,   16'h0000, 16'h0000},
    {4'd7,  OP_RSTART, 16'h0000, 16'h0000},
    {4'd7,  OP_RD,     16'h0000, 16'h003C}, // R7 input port 0
    {4'd4,  OP_RD,     16'h0000, 16'h00A5}, // R4 toggle to port 1
    {4'd4,  OP_RD,     16'h0000, 16'h003C}, // R4 back to port 0
    {4'd2,  OP_WCMD,   16'h0002, 16'h0000},
    {4'd6,  OP_WDAT,   16'h0012, 16'h0000},
    {4'd6,  OP_WDAT,   16'h0034, 16'h0000},
    {4'd6,  OP_CKOUT,  16'h3412, 16'h0000}, // R6 output values, direction still input
    {4'd2,  OP_WCMD,   16'h0006, 16'h0000},
    {4'd6,  OP_WDAT,   16'h00F0, 16'h0000},
    {4'd6,  OP_WDAT,   16'h000F, 16'h0000},
    {4'd6,  OP_CKOUT,  16'h3412, 16'hF00F}, // R6 enables follow direction
    {4'd2,  OP_WCMD,   16'h0004, 16'h0000},
    {4'd7,  OP_WDAT,   16'h00FF, 16'h0000},
    {4'd7,  OP_WDAT,   16'h0000, 16'h0000},
    {4'd2,  OP_WCMD,   16'h0000, 16'h0000},
    {4'd7,  OP_RSTART, 16'h0000, 16'h0000},
    {4'd7,  OP_RD,     16'h0000, 16'h00C3}, // R7 inverted port 0
    {4'd7,  OP_RD,     16'h0000, 16'h00A5}, // R7 port 1 not inverted
    {4'd5,  OP_WCMD,   16'h0007, 16'h0000},
    {4'd5,  OP_RSTART, 16'h0000, 16'h0000},
    {4'd5,  OP_RD,     16'h0000, 16'h000F}, // R5 and R10 direction port 1
    {4'd10, OP_RD,     16'h0000, 16'h00F0}, // R10 direction port 0
    {4'd3,  OP_RSTART, 16'h0000, 16'h0000},
    {4'd3,  OP_RCMD,   16'h0002, 16'h0000},
    {4'd3,  OP_RD,     16'h0000, 16'h000F}, // R3 pointer untouched
    {4'd9,  OP_WCMD,   16'h0001, 16'h0000},
    {4'd9,  OP_WDAT,   16'h0055, 16'h0000},
    {4'd9,  OP_WDAT,   16'h0066, 16'h0000},
    {4'd9,  OP_CKOUT,  16'h3412, 16'hF00F}, // R9 nothing changed
    {4'd9,  OP_RSTART, 16'h0000, 16'h0000},
    {4'd9,  OP_RD,     16'h0000, 16'h00A5}, // R9 pointer toggled twice
    {4'd2,  OP_WCMD,   16'h00FA, 16'h0000}, // R2 upper bits ignored -> 2
    {4'd10, OP_RD,     16'h0000, 16'h0012}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_start, rd_start, byte_valid, byte_first, byte_req;
  logic [7:0]  byte_data;
  logic [7:0]  rd_data;
  logic [15:0] pin_in, pin_out, pin_oe;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpx_regbank dut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rd_start(rd_start),
    .byte_valid(byte_valid), .byte_first(byte_first), .byte_data(byte_data),
    .byte_req(byte_req), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wcmd(input logic [7:0] d);
    wr_start = 1'b1; step(); wr_start = 1'b0;
    byte_valid = 1'b1; byte_first = 1'b1; byte_data = d; step();
    byte_valid = 1'b0; byte_first = 1'b0;
  endtask

  task automatic wdat(input logic [7:0] d);
    byte_valid = 1'b1; byte_data = d; step(); byte_valid = 1'b0;
  endtask

  task automatic rstart();
    rd_start = 1'b1; step(); rd_start = 1'b0;
  endtask

  task automatic rcmd(input logic [7:0] d);
    byte_valid = 1'b1; byte_first = 1'b1; byte_data = d; step();
    byte_valid = 1'b0; byte_first = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] exp);
    byte_req = 1'b1; step(); byte_req = 1'b0;
    check(req, "rd_data", {8'h00, rd_data}, {8'h00, exp});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL all watchdog actual=%0d cycles expected=fewer", WD_CYCLES);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_start = 1'b0; rd_start = 1'b0; byte_valid = 1'b0;
    byte_first = 1'b0; byte_req = 1'b0; byte_data = 8'h00; pin_in = 16'h0000;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    // R1 reset state
    check("R1", "pin_out", pin_out, 16'hFFFF);
    check("R1", "pin_oe", pin_oe, 16'h0000);
    check("R1", "rd_data", {8'h00, rd_data}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  rq;
      logic [2:0]  op;
      logic [15:0] dv, ev;
      string       tag;
      {rq, op, dv, ev} = VEC[i];
      tag = $sformatf("R%0d", rq);
      case (op)
        OP_PIN:    begin pin_in = dv; repeat (4) step(); end
        OP_WCMD:   wcmd(dv[7:0]);
        OP_WDAT:   wdat(dv[7:0]);
        OP_RSTART: rstart();
        OP_RD:     rd(tag, ev[7:0]);
        OP_CKOUT:  begin check(tag, "pin_out", pin_out, dv); check(tag, "pin_oe", pin_oe, ev); end
        OP_RCMD:   rcmd(dv[7:0]);
        default:   ;
      endcase
    end

    // R1 reset in the middle of a run restores every default
    rst_n = 1'b0; repeat (2) step();
    rst_n = 1'b1; repeat (3) step();
    check("R1", "pin_out after reset", pin_out, 16'hFFFF);
    check("R1", "pin_oe after reset", pin_oe, 16'h0000);
    pin_in = 16'h00AA; repeat (4) step();
    rstart();
    rd("R1", 8'hAA);      // pointer back at 0, polarity cleared
    rd("R8", 8'h00);      // port 1, pointer returns to 0

    // R8 pin change in the request cycle is not seen; byte then holds
    byte_req = 1'b1; pin_in = 16'h0055; step(); byte_req = 1'b0;
    check("R8", "capture same cycle", {8'h00, rd_data}, 16'h00AA);
    repeat (5) step();
    check("R8", "hold after capture", {8'h00, rd_data}, 16'h00AA);
    rd("R8", 8'h00);
    rd("R8", 8'h55);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule